// File: doc/BRIEF.md
# Host Remote DMA Engine

This block gives a host processor byte access to the controller's local packet memory without a memory-mapped window. The host loads a 16-bit start address and a 16-bit byte count into four page-0 registers, then writes a command that selects a read or a write transfer. From then on every host access to the data port moves exactly one byte between the host bus and local memory, and the engine advances the address and reduces the count by one.

For reads, the engine fetches the byte at the current address ahead of time, so the byte is already waiting when the host reads the port. The address follows the receive ring. Stepping past the last byte of the ring's stop page takes it back to the first byte of the ring's start page, so a frame that crosses the end of the ring can be read in one transfer. When the count reaches zero the engine goes idle and raises a sticky completion flag. The host clears this flag by writing a one to its bit in the status register. An abort command stops a transfer at once and does not raise the flag.

Top module: `rdma_engine`

## Requirements
- R1: After reset the engine is idle (`busy` = 0), `doneFlag` = 0, `memRe` = 0, `memWe` = 0, and `busRdData` = 0x00.
- R2: When the page field (bits 7:6 of the last write to offset 0x00) is 0, writes to offsets 0x08 and 0x09 load the address low and high bytes, and writes to 0x0A and 0x0B load the count low and high bytes. When the page field is not 0, these writes are ignored.
- R3: A write to offset 0x00 with bits 5:3 = 3'b001 and a nonzero count starts a read. A read strobe at any offset 0x10 to 0x17, made at least 3 cycles after the previous command or strobe, returns the memory byte at the current address on `busRdData` in the same cycle. The address then advances by one.
- R4: A write to offset 0x00 with bits 5:3 = 3'b010 and a nonzero count starts a write. Each write strobe at an offset from 0x10 to 0x17 drives `memWe` = 1 in the same cycle, with `memAddr` = the current address and `memWrData` = `busWrData`. The address then advances by one.
- R5: On the clock edge that ends the access which brings the count to zero, `busy` falls and `doneFlag` (status bit 6) rises.
- R6: An address increment from the last byte of page RING_STOP-1 (0x5FFF by default) goes to the first byte of page RING_START (0x4C00 by default).
- R7: While the engine is idle, data-port strobes cause no `memWe` and no `memRe`, and a data-port read returns 0x00.
- R8: A write to offset 0x00 with bit 5 set aborts the transfer. On the next edge `busy` is 0 and `doneFlag` keeps its value, and later data-port reads return 0x00.
- R9: With page field 0, a write to offset 0x07 with bit 6 set clears `doneFlag`. A write with bit 6 clear leaves it unchanged.
- R10: A read or write command issued while the count is zero leaves the engine idle and sets `doneFlag` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Host write strobe, one cycle per access |
| busRd | input | 1 | Host read strobe, one cycle per access |
| busAddr | input | 5 | Host register offset |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Data-port read byte, 0x00 when not a valid read |
| memAddr | output | 16 | Local memory address |
| memRe | output | 1 | Local memory read enable, data returned one cycle later |
| memWe | output | 1 | Local memory write enable |
| memWrData | output | 8 | Local memory write data |
| memRdData | input | 8 | Local memory read data |
| busy | output | 1 | A transfer is active |
| doneFlag | output | 1 | Sticky transfer-complete status (bit 6) |

## Verification
The hardest case to reach is a read that crosses the end of the ring. The host must program a start address two bytes below the wrap point with a count of four, and then strobe the port with spacing that lets each prefetch land. Only then does the third byte show whether the prefetch followed the wrapped address. The bench takes this route and checks every returned byte against a pattern it computes from the expected address. A second hard case is the page-gated address load. The bench switches to a non-zero page, writes an address byte that must be dropped, switches back, and reads one byte to see which address the engine used.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [4:0] OFF_CMD     = 5'h00;
  localparam logic [4:0] OFF_STATUS  = 5'h07;
  localparam logic [4:0] OFF_ADDR_LO = 5'h08;
  localparam logic [4:0] OFF_ADDR_HI = 5'h09;
  localparam logic [4:0] OFF_CNT_LO  = 5'h0A;
  localparam logic [4:0] OFF_CNT_HI  = 5'h0B;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dmaState_t;

  typedef struct packed {
    logic ldAddrLo;
    logic ldAddrHi;
    logic ldCntLo;
    logic ldCntHi;
    logic step;
    logic capture;
  } dmaStb_t;
endpackage

// File: rtl/rdma_dpath.sv
module rdma_dpath
  import rdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 8,
  parameter int RING_START = 8'h4C,
  parameter int RING_STOP  = 8'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStb_t           stb,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] rdBuf,
  output logic              countIsZero,
  output logic              countIsOne
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] WRAP_AT   = {PAGE_W'(RING_STOP), 8'h00};
  localparam logic [ADDR_W-1:0] WRAP_TO   = {PAGE_W'(RING_START), 8'h00};
  localparam logic [ADDR_W-1:0] LAST_BYTE = WRAP_AT - 1'b1;

  logic [CNT_W-1:0]  curCount;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign incAddr     = curAddr + 1'b1;
  assign nextAddr    = (incAddr == WRAP_AT) ? WRAP_TO : incAddr;
  assign countIsZero = (curCount == '0);
  assign countIsOne  = (curCount == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curCount <= '0;
      rdBuf    <= '0;
    end else begin
      if (stb.ldAddrLo) curAddr[7:0]        <= wrByte;
      if (stb.ldAddrHi) curAddr[ADDR_W-1:8] <= wrByte[PAGE_W-1:0];
      if (stb.ldCntLo)  curCount[7:0]       <= wrByte;
      if (stb.ldCntHi)  curCount[CNT_W-1:8] <= wrByte[CNT_W-9:0];
      if (stb.step) begin
        curAddr  <= nextAddr;
        curCount <= curCount - 1'b1;
      end
      if (stb.capture) rdBuf <= memRdData;
    end
  end

  // R6: ring wrap from the last byte of the stop-1 page
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && curAddr == LAST_BYTE) |=> (curAddr == WRAP_TO));

  // R5: every accepted access consumes one count
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.ldCntLo && !stb.ldCntHi) |=> (curCount == $past(curCount) - 1'b1));
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [4:0] busAddr,
  input  logic [4:0] cmdBits,
  input  logic       countIsZero,
  input  logic       countIsOne,
  output dmaStb_t    stb,
  output logic       busy,
  output logic       reading,
  output logic       doneFlag,
  output logic       memRe,
  output logic       memWe
);
  dmaState_t  state;
  logic [1:0] pageQ;
  logic       fetchQ;
  logic       captureQ;
  logic       portHit, regWrP0, cmdWr, doneClr, rdAct, wrAct;
  logic [2:0] cmdField;

  assign cmdField = cmdBits[2:0];
  assign portHit  = (busAddr[4:3] == 2'b10);
  assign regWrP0  = busWr && (pageQ == 2'd0);
  assign cmdWr    = busWr && (busAddr == OFF_CMD);
  assign doneClr  = regWrP0 && (busAddr == OFF_STATUS) && cmdBits[3];
  assign reading  = (state == ST_READ);
  assign busy     = (state != ST_IDLE);
  assign rdAct    = busRd && portHit && reading;
  assign wrAct    = busWr && portHit && (state == ST_WRITE);
  assign memWe    = wrAct;
  assign memRe    = fetchQ && reading;

  always_comb begin
    stb          = '0;
    stb.ldAddrLo = regWrP0 && (busAddr == OFF_ADDR_LO);
    stb.ldAddrHi = regWrP0 && (busAddr == OFF_ADDR_HI);
    stb.ldCntLo  = regWrP0 && (busAddr == OFF_CNT_LO);
    stb.ldCntHi  = regWrP0 && (busAddr == OFF_CNT_HI);
    stb.step     = rdAct || wrAct;
    stb.capture  = captureQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pageQ    <= '0;
      fetchQ   <= 1'b0;
      captureQ <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      fetchQ   <= 1'b0;
      captureQ <= memRe;
      if (doneClr) doneFlag <= 1'b0;
      if (cmdWr) begin
        pageQ <= cmdBits[4:3];
        if (cmdField[2]) begin
          state <= ST_IDLE;
        end else if (cmdField == 3'b001 || cmdField == 3'b010) begin
          if (countIsZero) begin
            state    <= ST_IDLE;
            doneFlag <= 1'b1;
          end else begin
            state  <= (cmdField == 3'b001) ? ST_READ : ST_WRITE;
            fetchQ <= (cmdField == 3'b001);
          end
        end
      end else if (stb.step) begin
        if (countIsOne) begin
          state    <= ST_IDLE;
          doneFlag <= 1'b1;
        end else begin
          fetchQ <= reading;
        end
      end
    end
  end

  // R8: abort drops the transfer without touching the completion flag
  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdField[2]) |=> (!busy && doneFlag == $past(doneFlag)));

  // R9: clearing write removes the completion flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneClr |=> !doneFlag);

  // R5/R10: the flag rises only when the count is used up
  p_done_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(countIsOne) || $past(countIsZero)));
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int RING_START = 8'h4C,
  parameter int RING_STOP  = 8'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [4:0]        busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              busy,
  output logic              doneFlag
);
  dmaStb_t    stb;
  logic       reading, countIsZero, countIsOne;
  logic [7:0] rdBuf;

  rdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .cmdBits(busWrData[7:3]), .countIsZero(countIsZero), .countIsOne(countIsOne),
    .stb(stb), .busy(busy), .reading(reading), .doneFlag(doneFlag),
    .memRe(memRe), .memWe(memWe)
  );

  rdma_dpath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(8),
    .RING_START(RING_START), .RING_STOP(RING_STOP)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(busWrData), .memRdData(memRdData),
    .curAddr(memAddr), .rdBuf(rdBuf), .countIsZero(countIsZero), .countIsOne(countIsOne)
  );

  assign memWrData = busWrData;
  assign busRdData = (busRd && busAddr[4:3] == 2'b10 && reading) ? rdBuf : 8'h00;

  // R7: an idle engine leaves memory and the read port quiet
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && busRdData == 8'h00));
endmodule

// File: tb/sim_rdma_engine.sv
module sim_rdma_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData, memWrData, memRdData;
  logic [15:0] memAddr;
  logic memRe, memWe, busy, doneFlag;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rdma_engine u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWrData(memWrData), .memRdData(memRdData), .busy(busy),
    .doneFlag(doneFlag)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) if (memRe) memRdData <= pat(memAddr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] n);
    wrReg(5'h08, a[7:0]); wrReg(5'h09, a[15:8]);
    wrReg(5'h0A, n[7:0]); wrReg(5'h0B, n[15:8]);
  endtask

  task automatic portRead(input logic [4:0] a, output logic [7:0] d);
    repeat (3) @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic portWrite(input logic [4:0] a, input logic [7:0] d, input logic [15:0] expAddr,
                           input bit expWe);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    #1;
    check(memWe == expWe, "R4/R7 memWe", memWe, expWe);
    if (expWe) begin
      check(memAddr == expAddr, "R4 memAddr", memAddr, expAddr);
      check(memWrData == d, "R4 memWrData", memWrData, d);
    end
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(doneFlag == 1'b0, "R1 doneFlag", doneFlag, 0);
    check(memRe == 1'b0 && memWe == 1'b0, "R1 mem enables", {memRe, memWe}, 0);
    portRead(5'h10, d);
    check(d == 8'h00, "R1 read data", d, 0);
  endtask

  task automatic t_read();
    logic [7:0] d;
    setup(16'h1234, 16'd3);
    wrReg(5'h00, 8'h0A);
    for (int i = 0; i < 3; i++) begin
      portRead(5'h10 + 5'(i), d);
      check(d == pat(16'h1234 + 16'(i)), "R3 read byte", d, pat(16'h1234 + 16'(i)));
      if (i < 2) check(busy == 1'b1, "R3 busy mid-transfer", busy, 1);
    end
    check(busy == 1'b0, "R5 busy after last", busy, 0);
    check(doneFlag == 1'b1, "R5 done after last", doneFlag, 1);
  endtask

  task automatic t_clear();
    wrReg(5'h07, 8'h00);
    check(doneFlag == 1'b1, "R9 clear without bit6", doneFlag, 1);
    wrReg(5'h07, 8'h40);
    check(doneFlag == 1'b0, "R9 clear with bit6", doneFlag, 0);
  endtask

  task automatic t_write();
    setup(16'h2000, 16'd2);
    wrReg(5'h00, 8'h12);
    check(busy == 1'b1, "R4 busy", busy, 1);
    portWrite(5'h10, 8'hA5, 16'h2000, 1'b1);
    portWrite(5'h17, 8'h5A, 16'h2001, 1'b1);
    check(busy == 1'b0 && doneFlag == 1'b1, "R5 write completion", {busy, doneFlag}, 1);
    wrReg(5'h07, 8'h40);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    logic [15:0] exp [4];
    exp[0] = 16'h5FFE; exp[1] = 16'h5FFF; exp[2] = 16'h4C00; exp[3] = 16'h4C01;
    setup(16'h5FFE, 16'd4);
    wrReg(5'h00, 8'h0A);
    for (int i = 0; i < 4; i++) begin
      portRead(5'h13, d);
      check(d == pat(exp[i]), "R6 wrap read byte", d, pat(exp[i]));
    end
    wrReg(5'h07, 8'h40);
  endtask

  task automatic t_idle();
    logic [7:0] d;
    portWrite(5'h11, 8'hEE, 16'h0000, 1'b0);
    portRead(5'h12, d);
    check(d == 8'h00, "R7 idle read", d, 0);
    check(memRe == 1'b0, "R7 idle memRe", memRe, 0);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    setup(16'h3000, 16'd5);
    wrReg(5'h00, 8'h0A);
    portRead(5'h10, d);
    check(d == pat(16'h3000), "R3 byte before abort", d, pat(16'h3000));
    wrReg(5'h00, 8'h22);
    check(busy == 1'b0, "R8 busy after abort", busy, 0);
    check(doneFlag == 1'b0, "R8 done after abort", doneFlag, 0);
    portRead(5'h10, d);
    check(d == 8'h00, "R8 read after abort", d, 0);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wrReg(5'h08, 8'h11); wrReg(5'h09, 8'h10);
    wrReg(5'h00, 8'h40);
    wrReg(5'h08, 8'h77);
    wrReg(5'h00, 8'h00);
    wrReg(5'h0A, 8'h01); wrReg(5'h0B, 8'h00);
    wrReg(5'h00, 8'h0A);
    portRead(5'h10, d);
    check(d == pat(16'h1011), "R2 page-1 address write ignored", d, pat(16'h1011));
    wrReg(5'h07, 8'h40);
  endtask

  task automatic t_zero();
    setup(16'h0100, 16'd0);
    wrReg(5'h00, 8'h12);
    check(busy == 1'b0, "R10 busy on zero count", busy, 0);
    check(doneFlag == 1'b1, "R10 done on zero count", doneFlag, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_clear();
    t_write();
    t_wrap();
    t_idle();
    t_abort();
    t_page();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule